// File: doc/BRIEF.md
# Inter-Processor Command Dispatcher

This block turns single register writes into commands aimed at one CPU of a multi-core cluster. Each written word carries a two-bit command kind, a target CPU number and a six-bit vector. Four kinds exist. An interrupt command sends an interrupt post, carrying the CPU number and the vector, towards the interrupt fabric. A reset command pulses the target's reset strobe and, on the next cycle, its activate strobe. An idle command pulses the target's halt strobe, which stops the core; a halted core does not wake on interrupts. A resume command pulses the target's activate strobe.

The block also takes the number of CPUs actually fitted. A command aimed at a CPU number at or above that count is dropped without any effect. A reset command whose vector is not the power-on-reset code is refused and raises a one-cycle error flag. All outputs are registered, so every effect appears one cycle after the write that caused it.

Top module: `ipi_dispatch`

## Requirements
- R1: The word is decoded with the command kind in bits 17:16, the target CPU in bits 12:8 and the vector in bits 5:0. Kind 0 (interrupt) sets `post_valid` for one cycle, in the cycle after the write, with `post_cpu` and `post_vec` equal to the written fields.
- R2: Kind 1 (reset) with a vector equal to `POR_CODE` (default 6'h01) sets bit `cpu` of `reset_strb` in the cycle after the write, and bit `cpu` of `activate_strb` in the cycle after that.
- R3: Kind 1 with any other vector produces no strobe and no post, and sets `bad_reset` for exactly one cycle, in the cycle after the write.
- R4: Kind 2 (idle) sets bit `cpu` of `halt_strb` in the cycle after the write.
- R5: Kind 3 (resume) sets bit `cpu` of `activate_strb` in the cycle after the write.
- R6: A write whose CPU field is greater than or equal to `cpus_present` has no effect: no post, no strobe and no `bad_reset`.
- R7: Each output pulses for one cycle per accepted command. When `wr_en` is low, and no reset follow-up is due, every output is zero and `post_cpu`/`post_vec` read zero.
- R8: While `rst` is high, every output reads zero in the cycle after the clock edge.
- R9: Bits of the written word outside the three fields do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the dispatch register |
| wr_data | input | 32 | Written word |
| cpus_present | input | 6 | Number of CPUs fitted, 0 to 32 |
| post_valid | output | 1 | Interrupt post valid |
| post_cpu | output | 5 | CPU receiving the interrupt |
| post_vec | output | 6 | Interrupt vector |
| reset_strb | output | 32 | Per-CPU reset pulse |
| halt_strb | output | 32 | Per-CPU halt pulse |
| activate_strb | output | 32 | Per-CPU activate pulse |
| bad_reset | output | 1 | Reset command refused for an unknown vector |

## Verification
On every cycle the assertions check that a post only follows a kind-0 write aimed at a fitted CPU, that each reset pulse is followed by an activate pulse on the same CPU, that a refused reset never comes with a reset pulse, that per-kind strobes stay one-hot, and that reset clears the outputs. The values carried (which CPU, which vector), the dropping of out-of-range targets including refused resets, the overlap of a reset follow-up with a fresh resume, and the indifference to stray bits only show through the bench's scenarios compared against its reference model.

// File: rtl/ipd_pkg.sv
package ipd_pkg;

    localparam int CPU_W    = 5;
    localparam int VEC_W    = 6;
    localparam int KIND_W   = 2;
    localparam int KIND_LSB = 16;
    localparam int CPU_LSB  = 8;
    localparam int VEC_LSB  = 0;
    localparam int NCPU     = 1 << CPU_W;

    typedef enum logic [KIND_W-1:0] {
        K_INTR   = 2'd0,
        K_RESET  = 2'd1,
        K_IDLE   = 2'd2,
        K_RESUME = 2'd3
    } kind_e;

    typedef struct packed {
        logic             valid;
        kind_e            kind;
        logic [CPU_W-1:0] cpu;
        logic [VEC_W-1:0] vec;
    } cmd_t;

    typedef struct packed {
        logic             post;
        logic [CPU_W-1:0] cpu;
        logic [VEC_W-1:0] vec;
        logic [NCPU-1:0]  rst;
        logic [NCPU-1:0]  halt;
        logic [NCPU-1:0]  act;
        logic             err;
    } outs_t;

    function automatic logic [NCPU-1:0] cpu_select(input logic [CPU_W-1:0] c);
        logic [NCPU-1:0] r;
        r = '0;
        for (int i = 0; i < NCPU; i++) begin
            r[i] = (c == CPU_W'(i));
        end
        return r;
    endfunction

endpackage

// File: rtl/ipd_decode.sv
module ipd_decode
    import ipd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CPU_W:0]    cpus_present,
    output cmd_t              cmd
);

    localparam int TOP_USED = KIND_LSB + KIND_W;

    logic [CPU_W-1:0] f_cpu;
    logic             in_range;
    logic             unused_bits;

    assign f_cpu    = wr_data[CPU_LSB +: CPU_W];
    assign in_range = ({1'b0, f_cpu} < cpus_present);

    always_comb begin
        cmd.valid = wr_en && in_range;
        cmd.kind  = kind_e'(wr_data[KIND_LSB +: KIND_W]);
        cmd.cpu   = f_cpu;
        cmd.vec   = wr_data[VEC_LSB +: VEC_W];
    end

    assign unused_bits = ^{wr_data[DATA_W-1:TOP_USED],
                           wr_data[KIND_LSB-1:CPU_LSB+CPU_W],
                           wr_data[CPU_LSB-1:VEC_LSB+VEC_W]};

endmodule

// File: rtl/ipd_pulse_gen.sv
module ipd_pulse_gen
    import ipd_pkg::*;
#(
    parameter logic [VEC_W-1:0] POR_CODE = 6'h01
) (
    input  logic  clk,
    input  logic  rst,
    input  cmd_t  cmd,
    output outs_t q
);

    outs_t           d;
    logic [NCPU-1:0] sel;

    assign sel = cpu_select(cmd.cpu);

    always_comb begin
        d     = '0;
        // second half of an accepted reset: wake the core one cycle later
        d.act = q.rst;
        if (cmd.valid) begin
            unique case (cmd.kind)
                K_INTR: begin
                    d.post = 1'b1;
                    d.cpu  = cmd.cpu;
                    d.vec  = cmd.vec;
                end
                K_RESET: begin
                    if (cmd.vec == POR_CODE) d.rst = sel;
                    else                     d.err = 1'b1;
                end
                K_IDLE:   d.halt = sel;
                K_RESUME: d.act  = d.act | sel;
                default:  d      = d;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
    import ipd_pkg::*;
#(
    parameter int               DATA_W   = 32,
    parameter logic [VEC_W-1:0] POR_CODE = 6'h01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CPU_W:0]    cpus_present,
    output logic              post_valid,
    output logic [CPU_W-1:0]  post_cpu,
    output logic [VEC_W-1:0]  post_vec,
    output logic [NCPU-1:0]   reset_strb,
    output logic [NCPU-1:0]   halt_strb,
    output logic [NCPU-1:0]   activate_strb,
    output logic              bad_reset
);

    cmd_t  cmd;
    outs_t q;

    ipd_decode #(.DATA_W(DATA_W)) u_dec (
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .cpus_present(cpus_present),
        .cmd         (cmd)
    );

    ipd_pulse_gen #(.POR_CODE(POR_CODE)) u_gen (
        .clk(clk),
        .rst(rst),
        .cmd(cmd),
        .q  (q)
    );

    assign post_valid    = q.post;
    assign post_cpu      = q.cpu;
    assign post_vec      = q.vec;
    assign reset_strb    = q.rst;
    assign halt_strb     = q.halt;
    assign activate_strb = q.act;
    assign bad_reset     = q.err;

endmodule

// File: rtl/ipi_dispatch_chk.sv
module ipi_dispatch_chk
    import ipd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [CPU_W:0]    cpus_present,
    input logic              post_valid,
    input logic [CPU_W-1:0]  post_cpu,
    input logic [NCPU-1:0]   reset_strb,
    input logic [NCPU-1:0]   halt_strb,
    input logic [NCPU-1:0]   activate_strb,
    input logic              bad_reset
);

    p_post_from_intr_r1: assert property (@(posedge clk) disable iff (rst)
        post_valid |-> ($past(wr_en) && $past(wr_data[KIND_LSB +: KIND_W]) == 2'd0));

    p_reset_then_wake_r2: assert property (@(posedge clk) disable iff (rst)
        (|reset_strb) |=> ((activate_strb & $past(reset_strb)) == $past(reset_strb)));

    p_refused_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        bad_reset |-> (reset_strb == '0 && !post_valid));

    p_post_in_range_r6: assert property (@(posedge clk) disable iff (rst)
        post_valid |-> ({1'b0, post_cpu} < $past(cpus_present)));

    p_single_target_r7: assert property (@(posedge clk) disable iff (rst)
        ($onehot0(reset_strb) && $onehot0(halt_strb)));

    p_idle_write_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_en) |-> (!post_valid && !bad_reset && halt_strb == '0 && reset_strb == '0));

    p_reset_clears_r8: assert property (@(posedge clk)
        rst |=> (!post_valid && !bad_reset && reset_strb == '0 &&
                 halt_strb == '0 && activate_strb == '0));

endmodule

bind ipi_dispatch ipi_dispatch_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .cpus_present (cpus_present),
    .post_valid   (post_valid),
    .post_cpu     (post_cpu),
    .reset_strb   (reset_strb),
    .halt_strb    (halt_strb),
    .activate_strb(activate_strb),
    .bad_reset    (bad_reset)
);

// File: tb/ipi_dispatch_tb.sv
module ipi_dispatch_tb;

    localparam int        NC  = 32;
    localparam logic [5:0] POR = 6'h01;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [5:0]  cpus_present = 6'd32;
    logic        post_valid;
    logic [4:0]  post_cpu;
    logic [5:0]  post_vec;
    logic [NC-1:0] reset_strb, halt_strb, activate_strb;
    logic        bad_reset;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    ipi_dispatch u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .cpus_present(cpus_present), .post_valid(post_valid),
        .post_cpu(post_cpu), .post_vec(post_vec), .reset_strb(reset_strb),
        .halt_strb(halt_strb), .activate_strb(activate_strb),
        .bad_reset(bad_reset)
    );

    // behavioural reference: expected outputs after each edge
    logic          e_post, e_err;
    logic [4:0]    e_cpu;
    logic [5:0]    e_vec;
    logic [NC-1:0] e_rst, e_halt, e_act;
    string         e_tag;

    initial begin
        e_post = 0; e_err = 0; e_cpu = 0; e_vec = 0;
        e_rst = '0; e_halt = '0; e_act = '0; e_tag = "R8";
    end

    always @(posedge clk) begin
        logic [NC-1:0] prev_rst;
        int            k, c, v;
        prev_rst = e_rst;
        e_post = 0; e_err = 0; e_cpu = 0; e_vec = 0;
        e_rst = '0; e_halt = '0; e_act = '0;
        if (rst) begin
            e_tag = "R8";
        end else begin
            e_act = prev_rst;
            e_tag = (prev_rst != 0) ? "R2" : "R7";
            if (wr_en) begin
                k = int'(wr_data[17:16]);
                c = int'(wr_data[12:8]);
                v = int'(wr_data[5:0]);
                if (c >= int'(cpus_present)) begin
                    e_tag = "R6";
                end else begin
                    case (k)
                        0: begin e_post = 1; e_cpu = 5'(c); e_vec = 6'(v); e_tag = "R1"; end
                        1: if (v == int'(POR)) begin e_rst[c] = 1'b1; e_tag = "R2"; end
                           else begin e_err = 1; e_tag = "R3"; end
                        2: begin e_halt[c] = 1'b1; e_tag = "R4"; end
                        default: begin e_act[c] = 1'b1; e_tag = "R5"; end
                    endcase
                end
                // R9: stray bits present in the word
                if ((wr_data & ~32'h0003_1F3F) != 0) e_tag = {e_tag, "/R9"};
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            n_checks++;
            if (post_valid !== e_post || post_cpu !== e_cpu || post_vec !== e_vec ||
                reset_strb !== e_rst || halt_strb !== e_halt ||
                activate_strb !== e_act || bad_reset !== e_err) begin
                n_fail++;
                $display("FAIL %s: got post=%0b cpu=%0d vec=%0h rst=%h halt=%h act=%h err=%0b, expected post=%0b cpu=%0d vec=%0h rst=%h halt=%h act=%h err=%0b",
                         e_tag, post_valid, post_cpu, post_vec, reset_strb, halt_strb,
                         activate_strb, bad_reset, e_post, e_cpu, e_vec, e_rst, e_halt,
                         e_act, e_err);
            end
        end
    end

    task automatic send(input int kind, input int cpu, input int vec, input logic [31:0] stray);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = stray | (32'(kind) << 16) | (32'(cpu) << 8) | 32'(vec);
    endtask

    task automatic quiet(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en   = 1'b0;
            wr_data = 32'hFFFF_FFFF;
        end
    endtask

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        quiet(3);
        @(negedge clk); rst = 1'b0;
        quiet(2);
        send(0, 3, 6'h2A, 0);               // R1
        send(1, 5, POR, 0);                 // R2
        quiet(3);
        send(1, 5, 6'h02, 0);               // R3
        send(2, 7, 0, 0);                   // R4
        send(3, 0, 0, 0);                   // R5
        send(0, 31, 6'h3F, 0);              // R1 top CPU
        quiet(2);
        cpus_present = 6'd4;
        send(0, 4, 6'h11, 0);               // R6
        send(1, 9, 6'h05, 0);               // R6 refused reset out of range
        send(3, 3, 0, 0);                   // R5 last fitted CPU
        cpus_present = 6'd0;
        send(2, 0, 0, 0);                   // R6 no CPUs
        cpus_present = 6'd32;
        send(1, 2, POR, 0);                 // R2 then overlap with resume
        send(3, 9, 0, 0);
        send(0, 1, 6'h15, 32'hFFFC_E0C0);   // R9
        send(2, 6, 6'h3F, 32'h8000_4080);   // R9
        quiet(2);
        send(1, 4, POR, 0);                 // R8 reset mid-sequence
        @(negedge clk); wr_en = 1'b0; rst = 1'b1;
        quiet(2);
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 400; i++) begin // mixed traffic
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cpus_present = 6'(int'(lfsr[5:0]) % 33);
            if (lfsr[9]) send(int'(lfsr[11:10]), int'(lfsr[14:10]), int'(lfsr[2:0]) % 3, 0);
            else quiet(1);
        end
        quiet(3);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule